// File: doc/BRIEF.md
# Double-Buffered Byte Serial Port with Handshake-Cleared Flags

This block is a byte-wide synchronous serial port that software runs through three registers: control, status and data. A byte written to the data register goes into a one-byte holding buffer. From there it moves into the shift register as soon as the shifter can take it, so software can queue a second byte while the first is still on the wire.

The port works either as master or as slave. As master it generates the serial clock from the bus clock, idle low, with a fixed number of bus clocks per half period. It sends most significant bit first and samples the input line on each rising edge. As slave it follows an external clock and an active-low select, both resynchronised into the bus clock domain.

Three status flags report transmit-buffer empty, receive-byte present and master-mode fault. Each flag clears only through a two-step handshake: first a status read that sees the flag at 1, then a matching access. A data write attempted without the first step is dropped. An interrupt request follows the transmit-empty flag when it is enabled.

Top module: `spi_dbuf`

## Requirements
- R1: After reset the status register reads 0x20, the control register reads 0x00, `irq` is 0 and `sck_out` is 0.
- R2: In master mode (control bit 0 = 1) a byte taken from the buffer is shifted out MSB first on `sdo`. Each bit lasts 2*HALF_DIV bus clocks, and `sdi` is sampled on each rising `sck_out` edge, so a loop from `sdo` to `sdi` returns the byte sent.
- R3: A data write (address 2) is accepted only if a status read (address 1) has seen transmit-empty (status bit 5) at 1 since the last accepted write. Any other data write is ignored and starts no transfer.
- R4: On an idle master, transmit-empty reads 0 in the access right after an accepted write and reads 1 again in the access after that, because the byte has reached the shifter.
- R5: While the shifter is busy, a second accepted byte waits in the buffer with transmit-empty at 0. When the running byte ends, the waiting byte is loaded at once, transmit-empty sets, and the byte is sent next.
- R6: Receive-full (status bit 7) sets when a byte completes. It clears only after a status read that sees it at 1 followed by a data read (address 2). A data read without that status read returns the byte and leaves the flag at 1.
- R7: If a byte completes while receive-full is 1, the new byte is discarded and the unread byte stays readable.
- R8: Mode fault (status bit 4) sets when `ss_n_in` is low only while master (ctrl bit 0), fault enable (ctrl bit 1) are 1 and select-output enable (ctrl bit 2) is 0.
- R9: Mode fault clears only after a status read that sees it at 1 followed by a control write (address 0). A control write without that status read leaves it set.
- R10: `irq` is 1 exactly while transmit-empty is 1 and transmit interrupt enable (ctrl bit 3) is 1.
- R11: In slave mode (ctrl bit 0 = 0), while `ss_n_in` is low, the port samples `sdi` on each rising `sck_in` edge and advances `sdo` on the falling edges between bits. The loaded byte goes out MSB first, and after 8 bits the received byte sets receive-full.
- R12: Register map: address 0 control (bits 3..0, upper bits read 0), address 1 status (bits 6 and 3..0 read 0), address 2 data, address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Transmit interrupt request |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_in | input | 1 | Serial clock received in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| ss_n_in | input | 1 | Active-low slave select / fault input |

## Verification
Read data is combinational, so any flag change from an access made at one clock edge is seen by the next access. Only the shifter load takes one more edge, so transmit-empty comes back in the second access after a write. The bench samples exactly there. A master byte takes 16*HALF_DIV bus clocks, so the bench either waits a fixed 80 clocks, which is more than one byte at the default divider and less than two, or polls status with a bound. Slave-side edges reach the logic about three clocks late through the synchroniser, so the bench holds every `sck_in` level for eight clocks and reads `sdo` just before each rising edge.

// File: rtl/spi_dbuf_pkg.sv
`timescale 1ns/1ps
package spi_dbuf_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic txie;
    logic ssoe;
    logic mfen;
    logic mstr;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  function automatic logic [BYTE_W-1:0] pack_status(logic rxf, logic tef, logic modf);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[7] = rxf;
    s[5] = tef;
    s[4] = modf;
    return s;
  endfunction

  function automatic logic fault_watch(ctrl_t c);
    return c.mstr & c.mfen & ~c.ssoe;
  endfunction
endpackage

// File: rtl/spi_dbuf_sync.sv
`timescale 1ns/1ps
module spi_dbuf_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_dbuf_shifter.sv
`timescale 1ns/1ps
module spi_dbuf_shifter
  import spi_dbuf_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              sdi_raw,
  input  logic              s_sck,
  input  logic              s_ss_n,
  input  logic              s_sdi,
  output logic              sck_out,
  output logic              sdo,
  output logic              ready,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned BW = $clog2(BYTE_W);
  localparam logic [CW-1:0] PH_LAST = CW'(HALF_DIV - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);

  logic              busy, hi, s_loaded, s_sck_q;
  logic [CW-1:0]     ph;
  logic [BW-1:0]     bitcnt;
  logic [BYTE_W-1:0] tx_sh, rx_sh;

  // named internal events
  logic m_tick, m_done, s_rise, s_fall, s_done;
  assign m_tick = busy && (ph == PH_LAST);
  assign m_done = master && m_tick && hi && (bitcnt == BIT_LAST);
  assign s_rise = !master && !s_ss_n && s_sck && !s_sck_q;
  assign s_fall = !master && !s_ss_n && !s_sck && s_sck_q;
  assign s_done = s_rise && (bitcnt == BIT_LAST);

  assign done    = m_done | s_done;
  assign ready   = master ? (!busy || m_done) : ((bitcnt == '0) && !s_loaded);
  assign rx_byte = master ? rx_sh : {rx_sh[BYTE_W-2:0], s_sdi};
  assign sck_out = master & hi;
  assign sdo     = tx_sh[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      hi       <= 1'b0;
      ph       <= '0;
      bitcnt   <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      s_loaded <= 1'b0;
      s_sck_q  <= 1'b0;
    end else begin
      s_sck_q <= s_sck;
      if (master) begin
        s_loaded <= 1'b0;
        if (load) begin
          busy   <= 1'b1;
          hi     <= 1'b0;
          ph     <= '0;
          bitcnt <= '0;
          tx_sh  <= load_byte;
        end else if (busy) begin
          if (m_tick) begin
            ph <= '0;
            if (!hi) begin
              hi    <= 1'b1;
              rx_sh <= {rx_sh[BYTE_W-2:0], sdi_raw};
            end else begin
              hi    <= 1'b0;
              tx_sh <= tx_sh << 1;
              if (bitcnt == BIT_LAST) begin
                busy   <= 1'b0;
                bitcnt <= '0;
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
      end else begin
        busy <= 1'b0;
        hi   <= 1'b0;
        ph   <= '0;
        if (load) begin
          tx_sh    <= load_byte;
          s_loaded <= 1'b1;
        end
        if (s_ss_n) begin
          bitcnt <= '0;
        end else if (s_rise) begin
          rx_sh <= {rx_sh[BYTE_W-2:0], s_sdi};
          if (s_done) begin
            bitcnt   <= '0;
            s_loaded <= 1'b0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end else if (s_fall && (bitcnt != '0)) begin
          tx_sh <= tx_sh << 1;
        end
      end
    end
  end

  // R2: serial clock stays low whenever no master byte is in flight
  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> !sck_out);

  // R2: a finished master byte leaves the shifter idle unless reloaded
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_done && !load) |=> !busy);

  // R11: a slave byte boundary returns the bit counter to zero
  p_slave_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (s_done && !master) |=> (bitcnt == '0));
endmodule

// File: rtl/spi_dbuf_flags.sv
`timescale 1ns/1ps
module spi_dbuf_flags
  import spi_dbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              ctrl_wr,
  input  logic              tx_moved,
  input  logic              rx_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              fault_det,
  input  logic              txie,
  output logic              tef,
  output logic              rxf,
  output logic              modf,
  output logic [BYTE_W-1:0] rx_q,
  output logic              tx_accept,
  output logic              irq
);
  logic arm_tx, arm_rx, arm_mf;
  logic rx_clr, mf_clr, rx_store;

  assign tx_accept = data_wr && arm_tx;
  assign rx_clr    = data_rd && arm_rx;
  assign mf_clr    = ctrl_wr && arm_mf;
  assign rx_store  = rx_done && (!rxf || rx_clr);
  assign irq       = tef && txie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tef    <= 1'b1;
      rxf    <= 1'b0;
      modf   <= 1'b0;
      arm_tx <= 1'b0;
      arm_rx <= 1'b0;
      arm_mf <= 1'b0;
      rx_q   <= '0;
    end else begin
      // transmit-empty and its arm
      if (tx_accept) begin
        tef    <= 1'b0;
        arm_tx <= 1'b0;
      end else begin
        if (tx_moved) tef <= 1'b1;
        if (stat_rd && tef) arm_tx <= 1'b1;
      end
      // receive-full and its arm
      if (rx_store) rx_q <= rx_byte;
      rxf <= (rxf && !rx_clr) || rx_done;
      if (rx_clr) arm_rx <= 1'b0;
      else if (stat_rd && rxf) arm_rx <= 1'b1;
      // mode fault and its arm
      modf <= fault_det || (modf && !mf_clr);
      if (mf_clr || !modf) arm_mf <= 1'b0;
      else if (stat_rd) arm_mf <= 1'b1;
    end
  end

  // R3: an unarmed data write leaves transmit-empty untouched
  p_tx_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !arm_tx && !tx_moved) |=> (tef == $past(tef)));

  // R4: moving a byte into the shifter frees the buffer
  p_tef_on_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_moved |=> tef);

  // R6: every completed byte leaves receive-full set
  p_rx_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rxf);

  // R7: an overrun keeps the unread byte
  p_overrun_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rxf && !rx_clr) |=> $stable(rx_q));

  // R9: mode fault only falls through the armed control write
  p_modf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(modf) |-> $past(ctrl_wr && arm_mf));

  // R10: an accepted write drops the request on the next cycle
  p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> !irq);
endmodule

// File: rtl/spi_dbuf.sv
`timescale 1ns/1ps
module spi_dbuf
  import spi_dbuf_pkg::*;
#(
  parameter int unsigned HALF_DIV    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sck_out,
  input  logic              sck_in,
  output logic              sdo,
  input  logic              sdi,
  input  logic              ss_n_in
);
  localparam int unsigned SYNC_W = 3;
  localparam logic [SYNC_W-1:0] SYNC_RST = 3'b010; // {sck, ss_n, sdi}

  ctrl_t             ctrl;
  logic [BYTE_W-1:0] tbuf, rx_q, rx_byte;
  logic              tbuf_full;
  logic              tef, rxf, modf, tx_accept;
  logic              sh_ready, sh_done, tx_moved, fault_det;
  logic [SYNC_W-1:0] sync_q;
  logic              s_sck, s_ss_n, s_sdi;
  reg_addr_e         addr;

  assign addr = reg_addr_e'(bus_addr);

  logic stat_rd, data_rd, data_wr, ctrl_wr;
  assign stat_rd = bus_rd && (addr == A_STAT);
  assign data_rd = bus_rd && (addr == A_DATA);
  assign data_wr = bus_wr && (addr == A_DATA);
  assign ctrl_wr = bus_wr && (addr == A_CTRL);

  spi_dbuf_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sck_in, ss_n_in, sdi}),
    .q    (sync_q)
  );
  assign {s_sck, s_ss_n, s_sdi} = sync_q;

  assign fault_det = fault_watch(ctrl) && !s_ss_n;
  assign tx_moved  = tbuf_full && sh_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      tbuf      <= '0;
      tbuf_full <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (tx_accept) begin
        tbuf      <= bus_wdata;
        tbuf_full <= 1'b1;
      end else if (tx_moved) begin
        tbuf_full <= 1'b0;
      end
    end
  end

  spi_dbuf_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .master   (ctrl.mstr),
    .load     (tx_moved),
    .load_byte(tbuf),
    .sdi_raw  (sdi),
    .s_sck    (s_sck),
    .s_ss_n   (s_ss_n),
    .s_sdi    (s_sdi),
    .sck_out  (sck_out),
    .sdo      (sdo),
    .ready    (sh_ready),
    .done     (sh_done),
    .rx_byte  (rx_byte)
  );

  spi_dbuf_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_rd  (stat_rd),
    .data_rd  (data_rd),
    .data_wr  (data_wr),
    .ctrl_wr  (ctrl_wr),
    .tx_moved (tx_moved),
    .rx_done  (sh_done),
    .rx_byte  (rx_byte),
    .fault_det(fault_det),
    .txie     (ctrl.txie),
    .tef      (tef),
    .rxf      (rxf),
    .modf     (modf),
    .rx_q     (rx_q),
    .tx_accept(tx_accept),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (addr)
      A_CTRL: bus_rdata = BYTE_W'(ctrl);
      A_STAT: bus_rdata = pack_status(rxf, tef, modf);
      A_DATA: bus_rdata = rx_q;
      A_NONE: bus_rdata = '0;
    endcase
  end

  // R5: transmit-empty and the buffer occupancy never disagree
  p_tef_vs_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tef != tbuf_full);

  // R3: an accepted write always fills the buffer
  p_accept_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_accept && !sh_ready) |=> tbuf_full);

  // R8: mode fault rises only under the watching configuration
  p_modf_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> $past(fault_watch(ctrl)));
endmodule

// File: tb/spi_dbuf_test.sv
`timescale 1ns/1ps
module spi_dbuf_test;
  localparam logic [1:0] AC = 2'd0, AS = 2'd1, AD = 2'd2, AN = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, sck_out, sdo, sdi;
  logic       sck_in = 1'b0, ss_n_in = 1'b1;
  logic       slave_tb = 1'b0, loop_inv = 1'b0, s_sdi_tb = 1'b0;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign sdi = slave_tb ? s_sdi_tb : (loop_inv ? ~sdo : sdo);

  spi_dbuf uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck_out(sck_out), .sck_in(sck_in), .sdo(sdo),
    .sdi(sdi), .ss_n_in(ss_n_in)
  );

  function automatic logic [7:0] st_exp(bit rx, bit te, bit mf);
    return (8'(rx) << 7) | (8'(te) << 5) | (8'(mf) << 4);
  endfunction

  function automatic logic [7:0] loop_exp(logic [7:0] b, bit inv);
    return inv ? (b ^ 8'hFF) : b;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] a, input logic [7:0] d,
                     output logic [7:0] q);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = !w; bus_wdata = d;
    #2 q = bus_rdata;
    @(posedge clk);
    #1 bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    acc(1'b0, a, 8'h00, q);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    acc(1'b1, a, d, dummy);
  endtask

  task automatic wait_rxf(output logic [7:0] st);
    st = '0;
    for (int k = 0; k < 300 && !st[7]; k++) rd(AS, st);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] q, st, a, b, got, pat;
    void'($urandom(32'h0005_EED5));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R12 reset values and map
    rd(AS, q); chk("R1 status after reset", q, st_exp(0, 1, 0));
    rd(AC, q); chk("R1 ctrl after reset", q, 8'h00);
    rd(AN, q); chk("R12 unused address reads zero", q, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    chk("R1 sck after reset", {7'b0, sck_out}, 8'h00);

    // R3 unarmed write: the status read above did arm, so reset again
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(2);
    wr(AC, 8'h01);
    wr(AD, 8'h77);
    idle(80);
    rd(AS, q); chk("R3 unarmed write ignored", q, st_exp(0, 1, 0));
    wr(AC, 8'hF1);
    rd(AC, q); chk("R12 ctrl upper bits read zero", q, 8'h01);

    // R4 idle fast path and R2 loopback
    rd(AS, q);
    wr(AD, 8'h3C);
    rd(AS, q); chk("R4 tef low right after write", q, st_exp(0, 0, 0));
    rd(AS, q); chk("R4 tef back in two cycles", q, st_exp(0, 1, 0));
    wait_rxf(st);
    rd(AD, q); chk("R2 loopback byte", q, loop_exp(8'h3C, 0));
    rd(AS, q); chk("R6 rxf cleared by handshake", q, st_exp(0, 1, 0));

    // R6 data read alone does not clear
    wr(AD, 8'h5A);
    idle(80);
    rd(AD, q); chk("R6 data readable without arm", q, 8'h5A);
    rd(AS, q); chk("R6 rxf kept without arm", q, st_exp(1, 1, 0));
    rd(AD, q);
    rd(AS, q); chk("R6 rxf cleared after arm", q, st_exp(0, 1, 0));

    // R7 overrun
    wr(AD, 8'hC3);
    idle(80);
    rd(AS, q);
    wr(AD, 8'h18);
    idle(80);
    rd(AS, q); chk("R7 rxf after overrun", q, st_exp(1, 1, 0));
    rd(AD, q); chk("R7 first byte kept", q, 8'hC3);
    rd(AS, q); chk("R7 overrun byte dropped", q, st_exp(0, 1, 0));

    // R5 queued second byte
    a = 8'h81; b = 8'h6E;
    wr(AD, a);
    rd(AS, q);
    rd(AS, q);
    wr(AD, b);
    rd(AS, q); chk("R5 buffer holds second byte", q, st_exp(0, 0, 0));
    wait_rxf(st);
    rd(AD, q); chk("R5 first queued byte", q, a);
    rd(AS, q); chk("R5 refill set tef", q, st_exp(0, 1, 0));
    wait_rxf(st);
    rd(AD, q); chk("R5 second queued byte", q, b);

    // R10 interrupt
    wr(AC, 8'h09);
    chk("R10 irq with tef and enable", {7'b0, irq}, 8'h01);
    rd(AS, q);
    wr(AD, 8'h24);
    @(negedge clk);
    chk("R10 irq drops after write", {7'b0, irq}, 8'h00);
    idle(2);
    chk("R10 irq back after move", {7'b0, irq}, 8'h01);
    wait_rxf(st);
    rd(AD, q);
    wr(AC, 8'h01);
    chk("R10 irq off when disabled", {7'b0, irq}, 8'h00);

    // R2 random bytes, both loop polarities
    for (int i = 0; i < 24; i++) begin
      a = 8'($urandom);
      loop_inv = 1'($urandom);
      rd(AS, q);
      wr(AD, a);
      wait_rxf(st);
      rd(AD, q); chk("R2 random transfer", q, loop_exp(a, loop_inv));
    end
    loop_inv = 1'b0;

    // R8 fault gated by select-output enable
    wr(AC, 8'h07);
    ss_n_in = 1'b0; idle(6);
    rd(AS, q); chk("R8 no fault with select output on", q, st_exp(0, 1, 0));
    ss_n_in = 1'b1; idle(6);
    wr(AC, 8'h03);
    ss_n_in = 1'b0; idle(6);
    ss_n_in = 1'b1; idle(6);
    wr(AC, 8'h03);
    rd(AS, q); chk("R9 unarmed ctrl write keeps fault", q, st_exp(0, 1, 1));
    wr(AC, 8'h03);
    rd(AS, q); chk("R9 fault cleared by handshake", q, st_exp(0, 1, 0));

    // R11 slave transfer
    wr(AC, 8'h00);
    slave_tb = 1'b1;
    pat = 8'($urandom);
    rd(AS, q);
    wr(AD, 8'hA5);
    idle(6);
    ss_n_in = 1'b0; idle(6);
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      s_sdi_tb = pat[i];
      idle(8);
      got[i] = sdo;
      sck_in = 1'b1; idle(8);
      sck_in = 1'b0;
    end
    idle(8);
    ss_n_in = 1'b1; idle(4);
    chk("R11 slave output bits", got, 8'hA5);
    rd(AS, q); chk("R11 slave status", q, st_exp(1, 1, 0));
    rd(AD, q); chk("R11 slave received byte", q, pat);
    slave_tb = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule